// File: doc/BRIEF.md
# ARINC 429 Host Register Interface

This block is the processor-facing register front end of an ARINC 429 controller. A host reaches it over a synchronous bus with active-low read and write enables and a 9-bit address. The address names a channel, a direction, a register and a slice. For every implemented channel and each direction there is a data register, a control byte, a status byte and a label byte. The host bus width is set at build time to 8, 16 or 32 bits. A 32-bit ARINC word therefore crosses the bus in four, two or one slices.

On the transmit side, the slices written by the host are assembled into a holding word. Writing the top slice commits that word to a small per-channel buffer, which the serial encoder drains through a valid/take pair. On the receive side, words arrive from the decoder through a per-channel put strobe into a small buffer. The host reads the oldest word slice by slice, and the read of the top slice removes it. Every access raises a wait output for a fixed number of clocks, and the read data is held until the host releases its enable. An interrupt output combines per-channel conditions that the host enables through the control bytes.

Top module: `a429_host_regs`

## Requirements
- R1: The address decodes as channel = bits 8:5, direction = bit 4 (1 transmit, 0 receive), register = bits 3:2 (0 data, 1 control, 2 status, 3 label) and slice = bits 1:0. Each channel and direction owns separate registers.
- R2: The control and label bytes are read/write. They appear in bits 7:0 of the bus with the upper bits zero, and only at slice 0. Other slices read zero and ignore writes.
- R3: Slice k of a transmit data register holds bits [k*W+W-1:k*W] of the assembled word, where W is the host width, and can be read back. Writing the top slice (index 32/W-1) commits the assembled word to that channel's transmit buffer.
- R4: The transmit buffer presents its oldest word with a valid flag, in commit order. A take pulse removes that word. A commit made while the buffer holds BUF_DEPTH words is dropped.
- R5: Reading slice k of a receive data register returns that slice of the oldest received word, or zero when the buffer is empty. Reading the top slice removes the word. Host writes to a receive data register have no effect.
- R6: A word put by the line side while the receive buffer holds BUF_DEPTH words is dropped.
- R7: The status byte reads bit 0 = buffer holds at least one word and bit 1 = buffer full, for the addressed direction. Writes to it have no effect.
- R8: Wait rises the clock after an enable is first sampled low in idle. It stays high for DATA_WAIT clocks on a data register of an implemented channel and for one clock otherwise. It then stays low, with the read data held, until both enables are high. Holding an enable low after completion never starts a second access.
- R9: The interrupt is the OR over channels of (receive control bit 0 AND receive buffer not empty) and (transmit control bit 0 AND transmit buffer empty).
- R10: Any access to a channel number of NUM_CH or above reads zero, changes no state and completes with a one-clock wait.
- R11: On a data register, a slice index of 32/W or above reads zero, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Host read enable, active low |
| wr_n | input | 1 | Host write enable, active low |
| addr | input | 9 | Packed channel/direction/register/slice address |
| wdata | input | HOST_W | Host write data |
| rdata | output | HOST_W | Host read data, held after completion |
| host_wait | output | 1 | High while the access is in progress |
| irq | output | 1 | Interrupt, active high |
| tx_word | output | NUM_CH*32 | Oldest transmit word per channel |
| tx_valid | output | NUM_CH | Transmit buffer holds a word |
| tx_take | input | NUM_CH | Line side removes the presented word |
| rx_word | input | NUM_CH*32 | Received word per channel |
| rx_put | input | NUM_CH | Line side stores rx_word into the buffer |

## Verification
The hardest case to reach is the interaction of a full receive buffer, a sliced read that pops, and a host that keeps its enable low after completion. Getting there takes line-side puts beyond the buffer depth, then reads of the top slice with the enable held for several extra clocks, then further reads that show exactly one word left each time. Transmit overflow is reached the same way, by committing more words than the depth before any take. The interrupt and line outputs are compared against a queue-based model on every clock, so an off-by-one in commit or pop timing shows up at once.

// File: rtl/a429_pkg.sv
package a429_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_BUSY = 2'd1,
        ACC_DONE = 2'd2
    } acc_st_e;

    localparam logic [1:0] RSEL_DATA = 2'd0;
    localparam logic [1:0] RSEL_CTRL = 2'd1;
    localparam logic [1:0] RSEL_STAT = 2'd2;
    localparam logic [1:0] RSEL_LBL  = 2'd3;

    // Field order matches the 9-bit address, MSB first (R1)
    typedef struct packed {
        logic [3:0] ch;
        logic       dir;
        logic [1:0] rsel;
        logic [1:0] slice;
    } a429_addr_t;

endpackage

// File: rtl/a429_addr_decode.sv
module a429_addr_decode
    import a429_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic [8:0]  addr_i,
    output a429_addr_t  fld_o,
    output logic        ch_ok_o
);

    // R1 field split, R10 implemented-channel test
    always_comb begin
        fld_o   = a429_addr_t'(addr_i);
        ch_ok_o = ({1'b0, fld_o.ch} < 5'(NUM_CH));
    end

endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
    parameter int DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_i,
    input  logic [31:0] data_i,
    input  logic        pop_i,
    output logic [31:0] head_o,
    output logic        empty_o,
    output logic        full_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][31:0] mem;
        logic [PW-1:0]          wp;
        logic [PW-1:0]          rp;
        logic [CW-1:0]          cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push_i && (q.cnt != CW'(DEPTH));
        do_pop  = pop_i && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wp] = data_i;
            d.wp        = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_o  = q.mem[q.rp];
    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == CW'(DEPTH));

endmodule

// File: rtl/a429_chan.sv
module a429_chan
    import a429_pkg::*;
#(
    parameter int HOST_W    = 16,
    parameter int BUF_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              wr_i,
    input  logic              dir_i,
    input  logic [1:0]        rsel_i,
    input  logic [1:0]        slice_i,
    input  logic [HOST_W-1:0] wdata_i,
    output logic [HOST_W-1:0] rd_o,
    output logic              irq_o,
    output logic [31:0]       tx_word_o,
    output logic              tx_valid_o,
    input  logic              tx_take_i,
    input  logic [31:0]       rx_word_i,
    input  logic              rx_put_i
);

    localparam int NSLICE = 32 / HOST_W;
    localparam logic [31:0] LANE = ~(32'hFFFF_FFFF << HOST_W);

    typedef struct packed {
        logic [7:0]  rx_ctrl;
        logic [7:0]  rx_lbl;
        logic [7:0]  tx_ctrl;
        logic [7:0]  tx_lbl;
        logic [31:0] tx_asm;
    } chan_t;

    chan_t       q, d;
    int          sl_idx;
    int          shamt;
    logic        slice_ok, slice_last, slice0;
    logic [31:0] merged, rd_word;
    logic [31:0] tx_head, rx_head;
    logic        tx_empty, tx_full, rx_empty, rx_full;
    logic        tx_push, rx_pop;

    always_comb begin
        sl_idx     = int'(slice_i);
        shamt      = sl_idx * HOST_W;
        slice_ok   = (sl_idx < NSLICE);           // R11
        slice_last = (sl_idx == NSLICE - 1);
        slice0     = (slice_i == 2'd0);           // R2
        merged     = (q.tx_asm & ~(LANE << shamt)) | (32'(wdata_i) << shamt);
    end

    // next-state of the register file
    always_comb begin
        d       = q;
        tx_push = 1'b0;
        rx_pop  = 1'b0;
        if (acc_i && wr_i) begin
            unique case (rsel_i)
                RSEL_DATA: begin
                    if (dir_i && slice_ok) begin      // R3: rx data writes ignored (R5)
                        d.tx_asm = merged;
                        tx_push  = slice_last;
                    end
                end
                RSEL_CTRL: begin
                    if (slice0) begin
                        if (dir_i) d.tx_ctrl = wdata_i[7:0];
                        else       d.rx_ctrl = wdata_i[7:0];
                    end
                end
                RSEL_LBL: begin
                    if (slice0) begin
                        if (dir_i) d.tx_lbl = wdata_i[7:0];
                        else       d.rx_lbl = wdata_i[7:0];
                    end
                end
                default: ;                            // R7: status is read-only
            endcase
        end
        if (acc_i && !wr_i && !dir_i && (rsel_i == RSEL_DATA) && slice_last) begin
            rx_pop = 1'b1;                            // R5
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // read path
    always_comb begin
        rd_word = '0;
        rd_o    = '0;
        unique case (rsel_i)
            RSEL_DATA: begin
                if (slice_ok) begin
                    if (dir_i)          rd_word = q.tx_asm;
                    else if (!rx_empty) rd_word = rx_head;
                    rd_o = HOST_W'(rd_word >> shamt);
                end
            end
            RSEL_CTRL: if (slice0) rd_o = HOST_W'(dir_i ? q.tx_ctrl : q.rx_ctrl);
            RSEL_STAT: begin
                if (slice0) begin
                    if (dir_i) rd_o = HOST_W'({6'b0, tx_full, !tx_empty});
                    else       rd_o = HOST_W'({6'b0, rx_full, !rx_empty});
                end
            end
            default:   if (slice0) rd_o = HOST_W'(dir_i ? q.tx_lbl : q.rx_lbl);
        endcase
    end

    a429_word_fifo #(.DEPTH(BUF_DEPTH)) u_txbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (tx_push),
        .data_i  (merged),
        .pop_i   (tx_take_i),
        .head_o  (tx_head),
        .empty_o (tx_empty),
        .full_o  (tx_full)
    );

    a429_word_fifo #(.DEPTH(BUF_DEPTH)) u_rxbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (rx_put_i),
        .data_i  (rx_word_i),
        .pop_i   (rx_pop),
        .head_o  (rx_head),
        .empty_o (rx_empty),
        .full_o  (rx_full)
    );

    assign tx_word_o  = tx_head;
    assign tx_valid_o = !tx_empty;
    assign irq_o      = (q.rx_ctrl[0] && !rx_empty) || (q.tx_ctrl[0] && tx_empty);  // R9

endmodule

// File: rtl/a429_host_regs.sv
module a429_host_regs
    import a429_pkg::*;
#(
    parameter int HOST_W    = 16,
    parameter int NUM_CH    = 2,
    parameter int BUF_DEPTH = 2,
    parameter int DATA_WAIT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic [8:0]            addr,
    input  logic [HOST_W-1:0]     wdata,
    output logic [HOST_W-1:0]     rdata,
    output logic                  host_wait,
    output logic                  irq,
    output logic [NUM_CH*32-1:0]  tx_word,
    output logic [NUM_CH-1:0]     tx_valid,
    input  logic [NUM_CH-1:0]     tx_take,
    input  logic [NUM_CH*32-1:0]  rx_word,
    input  logic [NUM_CH-1:0]     rx_put
);

    localparam int CNT_W = $clog2(DATA_WAIT + 1);

    typedef struct packed {
        acc_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        a429_addr_t        fld;
        logic              ok;
        logic [HOST_W-1:0] wd;
        logic [HOST_W-1:0] rd;
    } acc_t;

    acc_t              q, d;
    a429_addr_t        dec_fld;
    logic              dec_ok;
    logic              fin;
    logic [HOST_W-1:0] sel_rd;
    logic [HOST_W-1:0] ch_rd [NUM_CH];
    logic [NUM_CH-1:0] ch_irq;

    a429_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr_i  (addr),
        .fld_o   (dec_fld),
        .ch_ok_o (dec_ok)
    );

    // read mux over channels; zero for unimplemented ones (R10)
    always_comb begin
        sel_rd = '0;
        if (q.ok) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (q.fld.ch == 4'(c)) sel_rd = ch_rd[c];
            end
        end
    end

    // access sequencer (R8)
    always_comb begin
        d   = q;
        fin = 1'b0;
        unique case (q.st)
            ACC_IDLE: begin
                if (!rd_n || !wr_n) begin
                    d.st  = ACC_BUSY;
                    d.wr  = !wr_n;
                    d.fld = dec_fld;
                    d.ok  = dec_ok;
                    d.wd  = wdata;
                    d.cnt = (dec_ok && dec_fld.rsel == RSEL_DATA) ? CNT_W'(DATA_WAIT - 1) : '0;
                end
            end
            ACC_BUSY: begin
                if (q.cnt == '0) begin
                    fin  = 1'b1;
                    d.st = ACC_DONE;
                    if (!q.wr) d.rd = sel_rd;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ACC_DONE: if (rd_n && wr_n) d.st = ACC_IDLE;
            default:  d.st = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = fin && q.ok && (q.fld.ch == 4'(c));

        a429_chan #(
            .HOST_W    (HOST_W),
            .BUF_DEPTH (BUF_DEPTH)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .acc_i      (hit),
            .wr_i       (q.wr),
            .dir_i      (q.fld.dir),
            .rsel_i     (q.fld.rsel),
            .slice_i    (q.fld.slice),
            .wdata_i    (q.wd),
            .rd_o       (ch_rd[c]),
            .irq_o      (ch_irq[c]),
            .tx_word_o  (tx_word[c*32 +: 32]),
            .tx_valid_o (tx_valid[c]),
            .tx_take_i  (tx_take[c]),
            .rx_word_i  (rx_word[c*32 +: 32]),
            .rx_put_i   (rx_put[c])
        );
    end

    assign host_wait = (q.st == ACC_BUSY);
    assign rdata     = q.rd;
    assign irq       = |ch_irq;

endmodule

// File: rtl/a429_host_regs_chk.sv
module a429_host_regs_chk #(
    parameter int HOST_W    = 16,
    parameter int NUM_CH    = 2,
    parameter int DATA_WAIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              host_wait,
    input logic              st_idle,
    input logic              fin,
    input logic              op_ok,
    input logic              op_wr,
    input logic              op_data,
    input logic [HOST_W-1:0] rdata,
    input logic [NUM_CH-1:0] tx_valid,
    input logic [NUM_CH-1:0] tx_take
);

    int unsigned wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         wcnt <= 0;
        else if (host_wait) wcnt <= wcnt + 1;
        else                wcnt <= 0;
    end

    p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && (!rd_n || !wr_n)) |=> host_wait);

    p_wait_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_wait) |-> (wcnt == (op_data ? 32'(DATA_WAIT) : 32'd1)));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_idle && !host_wait && (!rd_n || !wr_n)) |=> !host_wait);

    p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !op_ok && !op_wr) |=> (rdata == '0));

    p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((tx_valid & $past(tx_valid & ~tx_take)) == $past(tx_valid & ~tx_take)));

endmodule

bind a429_host_regs a429_host_regs_chk #(
    .HOST_W    (HOST_W),
    .NUM_CH    (NUM_CH),
    .DATA_WAIT (DATA_WAIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .host_wait (host_wait),
    .st_idle   (q.st == a429_pkg::ACC_IDLE),
    .fin       (fin),
    .op_ok     (q.ok),
    .op_wr     (q.wr),
    .op_data   (q.ok && (q.fld.rsel == 2'd0)),
    .rdata     (rdata),
    .tx_valid  (tx_valid),
    .tx_take   (tx_take)
);

// File: tb/tb_a429_host_regs.sv
module tb_a429_host_regs;

    localparam int HW  = 16;
    localparam int NCH = 2;
    localparam int DEP = 2;
    localparam int DW  = 3;
    localparam int NS  = 32 / HW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [8:0]        addr = '0;
    logic [HW-1:0]     wdata = '0;
    logic [HW-1:0]     rdata;
    logic              host_wait;
    logic              irq;
    logic [NCH*32-1:0] tx_word;
    logic [NCH-1:0]    tx_valid;
    logic [NCH-1:0]    tx_take = '0;
    logic [NCH*32-1:0] rx_word = '0;
    logic [NCH-1:0]    rx_put = '0;

    a429_host_regs #(
        .HOST_W(HW), .NUM_CH(NCH), .BUF_DEPTH(DEP), .DATA_WAIT(DW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .host_wait(host_wait), .irq(irq),
        .tx_word(tx_word), .tx_valid(tx_valid), .tx_take(tx_take),
        .rx_word(rx_word), .rx_put(rx_put)
    );

    always #10 clk = ~clk;

    // reference model
    typedef logic [31:0] wq_t [$];
    wq_t        m_tx [NCH];
    wq_t        m_rx [NCH];
    logic [7:0] m_rxc [NCH];
    logic [7:0] m_rxl [NCH];
    logic [7:0] m_txc [NCH];
    logic [7:0] m_txl [NCH];
    logic [31:0] m_asm [NCH];

    int  n_chk = 0;
    int  n_bad = 0;
    bit  mon_on = 0;
    bit  done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] mk(input int ch, input bit dir, input int r, input int s);
        return {4'(ch), dir, 2'(r), 2'(s)};
    endfunction

    function automatic logic m_irq();
        logic v = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (m_rxc[c][0] && m_rx[c].size() > 0) v = 1'b1;
            if (m_txc[c][0] && m_tx[c].size() == 0) v = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [HW-1:0] m_read(input logic [8:0] a);
        int ch = int'(a[8:5]);
        int r  = int'(a[3:2]);
        int s  = int'(a[1:0]);
        bit dir = a[4];
        logic [31:0] w;
        if (ch >= NCH) return '0;
        case (r)
            0: begin
                if (s >= NS) return '0;
                if (dir) w = m_asm[ch];
                else     w = (m_rx[ch].size() > 0) ? m_rx[ch][0] : 32'd0;
                return w[s*HW +: HW];
            end
            1: return (s != 0) ? '0 : HW'(dir ? m_txc[ch] : m_rxc[ch]);
            2: begin
                if (s != 0) return '0;
                if (dir) return HW'({m_tx[ch].size() == DEP, m_tx[ch].size() > 0});
                return HW'({m_rx[ch].size() == DEP, m_rx[ch].size() > 0});
            end
            default: return (s != 0) ? '0 : HW'(dir ? m_txl[ch] : m_rxl[ch]);
        endcase
    endfunction

    task automatic m_update(input bit wr, input logic [8:0] a, input logic [HW-1:0] wd);
        int ch = int'(a[8:5]);
        int r  = int'(a[3:2]);
        int s  = int'(a[1:0]);
        bit dir = a[4];
        if (ch >= NCH) return;
        if (wr) begin
            if (r == 0 && dir && s < NS) begin
                m_asm[ch][s*HW +: HW] = wd;
                if (s == NS - 1 && m_tx[ch].size() < DEP) m_tx[ch].push_back(m_asm[ch]);
            end else if (r == 1 && s == 0) begin
                if (dir) m_txc[ch] = wd[7:0]; else m_rxc[ch] = wd[7:0];
            end else if (r == 3 && s == 0) begin
                if (dir) m_txl[ch] = wd[7:0]; else m_rxl[ch] = wd[7:0];
            end
        end else if (r == 0 && !dir && s == NS - 1 && m_rx[ch].size() > 0) begin
            void'(m_rx[ch].pop_front());
        end
    endtask

    // one host access; checks wait length (R8) and read data
    task automatic acc(input bit wr, input logic [8:0] a, input logic [HW-1:0] wd,
                       input string tag, input int hold);
        int n = 0;
        int exp_n;
        logic [HW-1:0] exp_rd;
        exp_rd = m_read(a);
        exp_n  = (int'(a[8:5]) < NCH && a[3:2] == 2'd0) ? DW : 1;
        @(negedge clk);
        addr  = a;
        wdata = wd;
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (host_wait) n++;
            else break;
        end
        chk({"R8 wait length ", tag}, 32'(n), 32'(exp_n));
        if (!wr) chk(tag, 32'(rdata), 32'(exp_rd));
        m_update(wr, a, wd);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R8 wait stays low while enable held", 32'(host_wait), 32'd0);
            if (!wr) chk("R8 read data held", 32'(rdata), 32'(exp_rd));
        end
        rd_n = 1'b1;
        wr_n = 1'b1;
    endtask

    task automatic wr_word(input int ch, input logic [31:0] w);
        for (int s = 0; s < NS; s++) acc(1'b1, mk(ch, 1'b1, 0, s), w[s*HW +: HW], "R3", 0);
    endtask

    task automatic line_put(input int ch, input logic [31:0] w);
        @(negedge clk);
        rx_word[ch*32 +: 32] = w;
        rx_put[ch] = 1'b1;
        @(posedge clk);
        if (m_rx[ch].size() < DEP) m_rx[ch].push_back(w);
        @(negedge clk);
        rx_put[ch] = 1'b0;
    endtask

    task automatic line_take(input int ch);
        @(negedge clk);
        tx_take[ch] = 1'b1;
        @(posedge clk);
        if (m_tx[ch].size() > 0) void'(m_tx[ch].pop_front());
        @(negedge clk);
        tx_take[ch] = 1'b0;
    endtask

    // per-clock comparison against the model (R4, R9)
    always @(negedge clk) begin
        if (mon_on) begin
            #5;
            chk("R9 irq", 32'(irq), 32'(m_irq()));
            for (int c = 0; c < NCH; c++) begin
                chk("R4 tx_valid", 32'(tx_valid[c]), 32'(m_tx[c].size() > 0));
                if (m_tx[c].size() > 0) chk("R4 tx_word order", tx_word[c*32 +: 32], m_tx[c][0]);
            end
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_rxc[c] = '0; m_rxl[c] = '0; m_txc[c] = '0; m_txl[c] = '0; m_asm[c] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R8 reset wait", 32'(host_wait), 32'd0);
        chk("R9 reset irq", 32'(irq), 32'd0);
        chk("R4 reset tx_valid", 32'(tx_valid), 32'd0);
        chk("R8 reset rdata", 32'(rdata), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;

        // R1 / R2: control and label bytes, separate per channel and direction
        acc(1, mk(0, 0, 1, 0), 16'h005A, "R2", 0);
        acc(1, mk(0, 1, 1, 0), 16'h00A4, "R2", 0);
        acc(1, mk(0, 0, 3, 0), 16'h0011, "R2", 0);
        acc(1, mk(0, 1, 3, 0), 16'h0022, "R2", 0);
        acc(1, mk(1, 0, 3, 0), 16'hFF33, "R2", 0);
        acc(0, mk(0, 0, 1, 0), 0, "R2 rx ctrl readback", 0);
        acc(0, mk(0, 1, 1, 0), 0, "R1 tx ctrl distinct", 0);
        acc(0, mk(0, 0, 3, 0), 0, "R1 rx label", 0);
        acc(0, mk(0, 1, 3, 0), 0, "R1 tx label", 0);
        acc(0, mk(1, 0, 3, 0), 0, "R1 channel 1 label, upper bits zero", 0);
        acc(1, mk(0, 0, 1, 1), 16'h00FF, "R2", 0);
        acc(0, mk(0, 0, 1, 0), 0, "R2 slice1 write ignored", 0);
        acc(0, mk(0, 0, 1, 1), 0, "R2 slice1 reads zero", 0);

        // R3: transmit assembly and commit
        acc(1, mk(1, 1, 0, 0), 16'hBEEF, "R3", 0);
        acc(0, mk(1, 1, 0, 0), 0, "R3 slice readback", 0);
        chk("R3 no commit before top slice", 32'(tx_valid[1]), 32'd0);
        acc(1, mk(1, 1, 0, 1), 16'hDEAD, "R3", 0);
        chk("R3 commit valid", 32'(tx_valid[1]), 32'd1);
        chk("R3 committed word", tx_word[32 +: 32], 32'hDEADBEEF);

        // R11: slice beyond the bus width
        acc(1, mk(1, 1, 0, 2), 16'h1234, "R11", 0);
        acc(0, mk(1, 1, 0, 2), 0, "R11 high slice reads zero", 0);
        acc(0, mk(1, 1, 0, 0), 0, "R11 write ignored", 0);

        // R4: transmit overflow and ordering
        wr_word(0, 32'h1111_0001);
        wr_word(0, 32'h2222_0002);
        wr_word(0, 32'h3333_0003);
        acc(0, mk(0, 1, 2, 0), 0, "R7 tx status full", 0);
        chk("R4 head first", tx_word[0 +: 32], 32'h1111_0001);
        line_take(0);
        chk("R4 head second", tx_word[0 +: 32], 32'h2222_0002);
        line_take(0);
        chk("R4 third dropped", 32'(tx_valid[0]), 32'd0);

        // R5 / R6 / R7: receive path
        line_put(0, 32'hAAAA_5555);
        line_put(0, 32'hBBBB_6666);
        line_put(0, 32'hCCCC_7777);
        acc(0, mk(0, 0, 2, 0), 0, "R7 rx status full", 0);
        acc(0, mk(0, 0, 0, 0), 0, "R5 oldest low slice", 0);
        acc(0, mk(0, 0, 0, 1), 0, "R5 oldest high slice pops", 3);
        acc(0, mk(0, 0, 0, 0), 0, "R5 single pop under held enable", 0);
        acc(1, mk(0, 0, 0, 1), 16'hFFFF, "R5", 0);
        acc(0, mk(0, 0, 0, 1), 0, "R5 rx write ignored", 0);
        acc(0, mk(0, 0, 0, 0), 0, "R6 third word dropped, empty reads zero", 0);
        acc(0, mk(0, 0, 2, 0), 0, "R7 rx status empty", 0);
        acc(1, mk(0, 0, 2, 0), 16'h00FF, "R7", 0);
        acc(0, mk(0, 0, 2, 0), 0, "R7 status write ignored", 0);

        // R9: interrupt sources
        acc(1, mk(1, 0, 1, 0), 16'h0001, "R9", 0);
        chk("R9 idle low", 32'(irq), 32'd0);
        line_put(1, 32'h0F0F_F0F0);
        chk("R9 rx source", 32'(irq), 32'd1);
        acc(0, mk(1, 0, 0, 0), 0, "R9", 0);
        acc(0, mk(1, 0, 0, 1), 0, "R9", 0);
        chk("R9 rx drained", 32'(irq), 32'd0);
        acc(1, mk(1, 1, 1, 0), 16'h0001, "R9", 0);
        chk("R9 tx not empty", 32'(irq), 32'd0);
        line_take(1);
        chk("R9 tx empty source", 32'(irq), 32'd1);

        // R10: unimplemented channels
        acc(1, mk(3, 0, 1, 0), 16'h0077, "R10", 0);
        acc(0, mk(3, 0, 1, 0), 0, "R10 unimplemented reads zero", 0);
        acc(0, mk(0, 0, 1, 0), 0, "R10 implemented ctrl untouched", 0);
        acc(1, mk(2, 1, 0, 0), 16'h4444, "R10", 0);
        acc(1, mk(2, 1, 0, 1), 16'h5555, "R10", 0);
        chk("R10 no transmit commit", 32'(tx_valid), 32'd0);
        acc(0, mk(15, 1, 0, 0), 0, "R10 channel 15 data", 0);

        repeat (4) @(negedge clk);
        mon_on = 0;
        done = 1;
        report();
        $finish;
    end

endmodule